// File: doc/BRIEF.md
# Counter-Flow Pipeline Flush Controller

This block coordinates recovery from timing errors in a five-stage in-order pipeline without ever stalling the whole pipeline at once. Four stages have timing-checked output registers: fetch, decode, execute and memory. Each of them can raise an error bit. Writeback is protected by a stabilising register, and the memory stage only performs non-speculative accesses, so writeback never reports an error.

When an error is accepted, the controller acts in three steps:
- In the same cycle it marks the failing slot as empty by raising a bubble flag for that stage.
- In the next cycle it tells that stage to re-inject its shadow copy, so the failing instruction continues with correct inputs.
- It launches a flush token that carries the failing stage number and walks one stage per cycle towards fetch. On its way the token squashes every younger instruction it meets.

When the token arrives at fetch, the controller issues a redirect to the address of the instruction after the failing one. Fetch is held idle for the whole recovery.

A second error that arrives during a recovery is accepted only if it comes from an instruction that is not younger than the one being recovered. An accepted second error restarts the recovery from its own stage. Errors from younger instructions are dropped, because those instructions are being squashed anyway.

Top module: `cfp_flush_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is zero: bubble, restore, squash, flush ID, busy, redirect and redirect address.
- R2: With busy low, the bubble output is combinational and one-hot. Its set bit is the highest-numbered asserted error bit: bit 0 is fetch, bit 3 is memory, and a higher number means an older instruction. With no error, the bubble output is zero.
- R3: The restore output is one-hot at the accepted stage index exactly in the cycle after the bubble, and zero in every other cycle.
- R4: For an accepted error from stage k, busy is high for the k+1 cycles that start the cycle after the error. It is low in the cycle after that.
- R5: While busy, the flush ID output equals the index of the stage whose error started the current recovery.
- R6: In the n-th busy cycle after the first (n = 1..k), the squash output is one-hot at stage k-n. It is zero in the first busy cycle and never marks stage k itself.
- R7: The redirect output pulses for one cycle, in the last busy cycle. In that cycle the redirect address equals the stage-k address sampled in the error cycle plus 4.
- R8: During a recovery, the failing instruction's position is k in the first busy cycle and rises by one each cycle after that. An error bit below that position raises no bubble and leaves the running recovery unchanged.
- R9: During a recovery, an error bit at or above the failing instruction's position is accepted. It raises its bubble at once and restarts the recovery from that stage, with the address sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_i | input | 4 | Timing error per checked stage (0 fetch .. 3 memory) |
| stage_pc_i | input | 128 | Instruction address held in each checked stage, 32 bits per stage, stage 0 in the low bits |
| bubble_o | output | 4 | Slot after this stage is empty (same cycle as the error) |
| restore_o | output | 4 | Re-inject the shadow value of this stage |
| squash_o | output | 4 | Flush token is at this stage; discard its instruction |
| flush_id_o | output | 2 | Stage index carried by the flush token |
| busy_o | output | 1 | Recovery in progress; fetch held idle |
| redirect_o | output | 1 | Restart fetch at redirect_pc_o |
| redirect_pc_o | output | 32 | Restart address |

## Verification
The hardest situations to reach are those where a second error arrives while a flush token is already moving. Whether that error is dropped or takes over depends on how far the failing instruction has advanced since the recovery began. The bench counts cycles from the first error and injects the second error at a chosen offset: first below the failing instruction's current position, where it must be ignored, and then from an older stage, where it must restart the flush with a fresh address. The redirect timing and address then show which recovery won.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  // Stage numbering of the checked pipeline registers; higher means older.
  typedef enum int unsigned {
    STG_FETCH  = 0,
    STG_DECODE = 1,
    STG_EXEC   = 2,
    STG_MEMORY = 3
  } stage_e;

  // Width of an index able to hold values 0..n-1, at least one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cfp_err_pick.sv
module cfp_err_pick #(
  parameter int unsigned NERR = 4,
  parameter int unsigned SW   = 2,
  parameter int unsigned FPW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] err_i,
  input  logic            busy_i,
  input  logic [FPW-1:0]  fpos_i,
  output logic            take_o,
  output logic [SW-1:0]   take_idx_o,
  output logic [NERR-1:0] bubble_o
);
  logic [NERR-1:0] elig;

  // An error is eligible when idle, or when it is not younger than the
  // instruction currently under recovery.
  always_comb begin
    for (int j = 0; j < NERR; j++) begin
      elig[j] = err_i[j] && (!busy_i || (j >= int'(fpos_i)));
    end
  end

  // Oldest eligible error wins.
  always_comb begin
    take_o     = 1'b0;
    take_idx_o = '0;
    for (int j = 0; j < NERR; j++) begin
      if (elig[j]) begin
        take_o     = 1'b1;
        take_idx_o = SW'(j);
      end
    end
  end

  always_comb begin
    bubble_o = '0;
    if (take_o) bubble_o[take_idx_o] = 1'b1;
  end

  AST_BUBBLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bubble_o)); // R2
  AST_BUBBLE_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (|bubble_o) |-> (|(bubble_o & err_i))); // R2
endmodule

// File: rtl/cfp_flush_token.sv
module cfp_flush_token #(
  parameter int unsigned NERR = 4,
  parameter int unsigned SW   = 2,
  parameter int unsigned FPW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic [SW-1:0]   take_idx_i,
  output logic            busy_o,
  output logic            first_o,
  output logic [SW-1:0]   tid_o,
  output logic [FPW-1:0]  fpos_o,
  output logic [NERR-1:0] squash_o,
  output logic            done_o
);
  localparam logic [FPW-1:0] FPOS_GONE = FPW'(NERR + 1);

  logic           act_q,   act_d;
  logic           first_q, first_d;
  logic [SW-1:0]  tpos_q,  tpos_d;
  logic [SW-1:0]  tid_q,   tid_d;
  logic [FPW-1:0] fpos_q,  fpos_d;
  logic           en;

  assign en = take_i | act_q | first_q;

  always_comb begin
    act_d   = act_q;
    first_d = 1'b0;
    tpos_d  = tpos_q;
    tid_d   = tid_q;
    fpos_d  = fpos_q;
    if (take_i) begin
      act_d   = 1'b1;
      first_d = 1'b1;
      tpos_d  = take_idx_i;
      tid_d   = take_idx_i;
      fpos_d  = FPW'(take_idx_i);
    end else if (act_q) begin
      if (tpos_q == '0) act_d  = 1'b0;
      else              tpos_d = tpos_q - 1'b1;
      if (fpos_q != FPOS_GONE) fpos_d = fpos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      first_q <= 1'b0;
      tpos_q  <= '0;
      tid_q   <= '0;
      fpos_q  <= '0;
    end else if (en) begin
      act_q   <= act_d;
      first_q <= first_d;
      tpos_q  <= tpos_d;
      tid_q   <= tid_d;
      fpos_q  <= fpos_d;
    end
  end

  for (genvar g = 0; g < NERR; g++) begin : g_sq
    assign squash_o[g] = act_q && (tpos_q == SW'(g)) && (tid_q > SW'(g));
  end

  assign busy_o  = act_q;
  assign first_o = first_q;
  assign tid_o   = tid_q;
  assign fpos_o  = fpos_q;
  assign done_o  = act_q && (tpos_q == '0);

  AST_SQUASH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(squash_o)); // R6
  AST_NO_SQUASH_FAILING: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> !squash_o[tid_q]); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !take_i) |=> !busy_o); // R4
  AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !take_i) |=> $stable(tid_o)); // R5
  AST_TAKE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (busy_o && first_o)); // R4
endmodule

// File: rtl/cfp_restart_pc.sv
module cfp_restart_pc #(
  parameter int unsigned NERR       = 4,
  parameter int unsigned SW         = 2,
  parameter int unsigned PCW        = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_i,
  input  logic                busy_i,
  input  logic [SW-1:0]       take_idx_i,
  input  logic [NERR*PCW-1:0] pc_flat_i,
  output logic [PCW-1:0]      rpc_o
);
  logic [PCW-1:0] pc_a [NERR];
  logic [PCW-1:0] rpc_q, rpc_d;

  for (genvar g = 0; g < NERR; g++) begin : g_unpack
    assign pc_a[g] = pc_flat_i[g*PCW +: PCW];
  end

  always_comb begin
    rpc_d = pc_a[take_idx_i] + PCW'(INSN_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rpc_q <= '0;
    else if (take_i) rpc_q <= rpc_d;
  end

  assign rpc_o = rpc_q;

  AST_RPC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !take_i) |=> $stable(rpc_o)); // R7
endmodule

// File: rtl/cfp_flush_ctrl.sv
module cfp_flush_ctrl #(
  parameter int unsigned NERR       = 4,
  parameter int unsigned PCW        = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NERR-1:0]     err_i,
  input  logic [NERR*PCW-1:0] stage_pc_i,
  output logic [NERR-1:0]     bubble_o,
  output logic [NERR-1:0]     restore_o,
  output logic [NERR-1:0]     squash_o,
  output logic [cfp_pkg::idx_w(NERR)-1:0] flush_id_o,
  output logic                busy_o,
  output logic                redirect_o,
  output logic [PCW-1:0]      redirect_pc_o
);
  localparam int unsigned SW  = cfp_pkg::idx_w(NERR);
  localparam int unsigned FPW = $clog2(NERR + 2);

  logic           take;
  logic [SW-1:0]  take_idx;
  logic           busy, first, done;
  logic [SW-1:0]  tid;
  logic [FPW-1:0] fpos;

  cfp_err_pick #(.NERR(NERR), .SW(SW), .FPW(FPW)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_i      (err_i),
    .busy_i     (busy),
    .fpos_i     (fpos),
    .take_o     (take),
    .take_idx_o (take_idx),
    .bubble_o   (bubble_o)
  );

  cfp_flush_token #(.NERR(NERR), .SW(SW), .FPW(FPW)) u_tok (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .take_idx_i (take_idx),
    .busy_o     (busy),
    .first_o    (first),
    .tid_o      (tid),
    .fpos_o     (fpos),
    .squash_o   (squash_o),
    .done_o     (done)
  );

  cfp_restart_pc #(.NERR(NERR), .SW(SW), .PCW(PCW), .INSN_BYTES(INSN_BYTES)) u_rpc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .busy_i     (busy),
    .take_idx_i (take_idx),
    .pc_flat_i  (stage_pc_i),
    .rpc_o      (redirect_pc_o)
  );

  always_comb begin
    restore_o = '0;
    if (first) restore_o[tid] = 1'b1;
  end

  assign flush_id_o = busy ? tid : '0;
  assign busy_o     = busy;
  assign redirect_o = done;

  AST_RESTORE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (restore_o == $past(bubble_o))); // R3
  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && !(|bubble_o)) |=> !redirect_o); // R7
  AST_REDIRECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> busy_o); // R7
endmodule

// File: tb/sim_cfp_flush_ctrl.sv
module sim_cfp_flush_ctrl;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   err_i;
  logic [127:0] stage_pc_i;
  logic [3:0]   bubble_o, restore_o, squash_o;
  logic [1:0]   flush_id_o;
  logic         busy_o, redirect_o;
  logic [31:0]  redirect_pc_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cfp_flush_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .err_i(err_i), .stage_pc_i(stage_pc_i),
    .bubble_o(bubble_o), .restore_o(restore_o), .squash_o(squash_o),
    .flush_id_o(flush_id_o), .busy_o(busy_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o)
  );

  // Stimulus table: error mask and the stage expected to win.
  localparam int NV = 7;
  localparam logic [3:0] VMASK [NV] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                        4'b0110, 4'b1011, 4'b0011};
  localparam int         VK    [NV] = '{0, 1, 2, 3, 2, 3, 1};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_pcs(input logic [31:0] base);
    for (int s = 0; s < 4; s++) stage_pc_i[s*32 +: 32] = base + 32'(s * 16);
  endtask

  // Called in the error cycle, after the bubble check; walks the recovery.
  task automatic walk(input int k, input logic [31:0] exp_pc);
    @(negedge clk); err_i = '0; #1;
    for (int n = 0; n <= k; n++) begin
      if (n > 0) begin @(negedge clk); #1; end
      chk(restore_o == ((n == 0) ? 4'(1 << k) : 4'b0), "R3 restore", restore_o, (n == 0) ? (1 << k) : 0);
      chk(busy_o == 1'b1, "R4 busy", busy_o, 1);
      chk(flush_id_o == 2'(k), "R5 flush id", flush_id_o, k);
      chk(squash_o == ((n == 0) ? 4'b0 : 4'(1 << (k - n))), "R6 squash", squash_o, (n == 0) ? 0 : (1 << (k - n)));
      chk(redirect_o == (n == k), "R7 redirect", redirect_o, (n == k));
      if (n == k) chk(redirect_pc_o == exp_pc, "R7 redirect pc", redirect_pc_o, exp_pc);
    end
    @(negedge clk); #1;
    chk(busy_o == 1'b0, "R4 busy end", busy_o, 0);
    chk(redirect_o == 1'b0, "R7 redirect end", redirect_o, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R4 watchdog actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; err_i = '0; set_pcs(32'h0);
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs quiet in reset
    chk({bubble_o, restore_o, squash_o, flush_id_o, busy_o, redirect_o} == '0, "R1 reset outs",
        {bubble_o, restore_o, squash_o, flush_id_o, busy_o, redirect_o}, 0);
    chk(redirect_pc_o == 32'h0, "R1 reset pc", redirect_pc_o, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk({restore_o, squash_o, busy_o, redirect_o} == '0, "R1 after reset",
        {restore_o, squash_o, busy_o, redirect_o}, 0);
    chk(bubble_o == 4'b0, "R2 no error no bubble", bubble_o, 0);

    // Table walk: R2..R7
    for (int v = 0; v < NV; v++) begin
      logic [31:0] base;
      base = 32'h1000 * 32'(v + 1);
      @(negedge clk); set_pcs(base); err_i = VMASK[v]; #1;
      chk(bubble_o == 4'(1 << VK[v]), "R2 bubble pick", bubble_o, 1 << VK[v]);
      walk(VK[v], base + 32'(VK[v] * 16) + 32'd4);
    end

    // R8: younger errors during a recovery are dropped
    @(negedge clk); set_pcs(32'h8000); err_i = 4'b0100; #1;
    chk(bubble_o == 4'b0100, "R2 bubble EX", bubble_o, 4'b0100);
    @(negedge clk); err_i = 4'b0000; #1;
    chk(restore_o == 4'b0100, "R3 restore EX", restore_o, 4'b0100);
    @(negedge clk); err_i = 4'b0110; set_pcs(32'h9000); #1;
    chk(bubble_o == 4'b0000, "R8 younger ignored", bubble_o, 0);
    chk(squash_o == 4'b0010, "R8 squash continues", squash_o, 4'b0010);
    @(negedge clk); err_i = 4'b0000; #1;
    chk(redirect_o == 1'b1, "R8 redirect on time", redirect_o, 1);
    chk(redirect_pc_o == 32'h8024, "R8 redirect pc kept", redirect_pc_o, 32'h8024);
    chk(flush_id_o == 2'd2, "R8 id kept", flush_id_o, 2);
    @(negedge clk); #1;
    chk(busy_o == 1'b0, "R8 busy end", busy_o, 0);

    // R9: older error during a recovery restarts the flush
    @(negedge clk); set_pcs(32'hA000); err_i = 4'b0010; #1;
    chk(bubble_o == 4'b0010, "R2 bubble ID", bubble_o, 4'b0010);
    @(negedge clk); err_i = 4'b1000; set_pcs(32'hB000); #1;
    chk(restore_o == 4'b0010, "R3 restore ID", restore_o, 4'b0010);
    chk(bubble_o == 4'b1000, "R9 older accepted", bubble_o, 4'b1000);
    walk(3, 32'hB034);

    // R9: error at the failing instruction's own position is accepted
    @(negedge clk); set_pcs(32'hC000); err_i = 4'b0001; #1;
    chk(bubble_o == 4'b0001, "R2 bubble IF", bubble_o, 1);
    @(negedge clk); err_i = 4'b0001; set_pcs(32'hD000); #1;
    chk(bubble_o == 4'b0001, "R9 same position accepted", bubble_o, 1);
    chk(redirect_pc_o == 32'hC004, "R7 first redirect pc", redirect_pc_o, 32'hC004);
    walk(0, 32'hD004);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule